// File: doc/BRIEF.md
# Twin-Predicated Element Mover

This block copies elements from a source vector into a destination vector while two separate predicate masks are applied at the same time. The source mask decides which source elements are taken; unselected source positions are skipped, so the taken elements close up (compress). The destination mask decides which destination slots are filled; unselected slots are stepped over, so the moved elements spread out (expand). Two indices walk the vectors in strict ascending order, as a hardware loop. One element moves in a cycle where both indices sit on set mask bits. The run stops as soon as either index reaches the vector length.

A predication mode picks how the two masks are formed. Twin mode uses both masks as given. Single mode uses one mask for both sides, so elements stay in place. Two one-sided modes force one mask to all ones, which gives a pure compress or a pure expand. For each move, the block reports the source index and the destination index it paired. A memory unit outside the block can use this pairing to tie a predicated address stream (source side) to a predicated data stream (destination side).

A run is started with a one-cycle `start` while the block is idle. The masks, length, mode and source data are captured at that edge. Destination slots that receive nothing keep their earlier contents, and their write-enable flags stay low.

Top module: `twin_pred_mover`

## Requirements
- R1: After reset `busy`, `done`, `mv_valid` and every `dst_we` bit are 0, and `dst_data` is all zeros.
- R2: With `mode` = 0 (twin), the k-th set source-mask bit below VL is paired with the k-th set destination-mask bit below VL, for every k below the smaller of the two set counts. Element i sits at bits [i*ELEM_W +: ELEM_W] of both data vectors.
- R3: A destination slot that receives no element keeps its earlier value and its `dst_we` bit is 0. `dst_we` is 1 exactly for the slots written in the latest run, and `dst_data` changes only at the edge where `mv_valid` rises for that write.
- R4: With `mode` = 1 (single), `src_mask` governs both sides and `dst_mask` is ignored, so each selected element i is written to slot i.
- R5: With `mode` = 2 (source-only), `dst_mask` is treated as all ones, so the selected source elements are packed into slots 0, 1, 2, and so on.
- R6: With `mode` = 3 (destination-only), `src_mask` is treated as all ones, so source elements 0, 1, 2, and so on go in order to the selected destination slots.
- R7: The run ends when either index reaches VL. A VL above NUM_ELEM is treated as NUM_ELEM. With VL = 0 the run ends with no writes.
- R8: Each move gives a one-cycle `mv_valid` with `mv_src_idx` and `mv_dst_idx`. Within a run both indices strictly increase, both lie below VL, and both point at set bits of the effective masks.
- R9: `done` is a one-cycle pulse, and `busy` is low while `done` is high. A `start` seen while `busy` is high is ignored.
- R10: In twin mode, with both masks all ones, the run is a plain element-by-element copy of the first VL elements.
- R11: `done` appears no later than 2*VL+1 rising edges after the edge that accepts `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted only while idle) |
| mode | input | 2 | Predication mode: 0 twin, 1 single, 2 source-only, 3 destination-only |
| vl | input | CW | Vector length, clamped to NUM_ELEM |
| src_mask | input | NUM_ELEM | Source predicate |
| dst_mask | input | NUM_ELEM | Destination predicate |
| src_data | input | NUM_ELEM*ELEM_W | Source element array |
| dst_data | output | NUM_ELEM*ELEM_W | Destination element array |
| dst_we | output | NUM_ELEM | Per-slot written-this-run flags |
| mv_valid | output | 1 | A move happened |
| mv_src_idx | output | CW | Source index of the move |
| mv_dst_idx | output | CW | Destination index of the move |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The assertions assume that reset is applied before the first run. They also assume that the captured masks, length and mode are what the moves are compared against. Because of this, the ordering and mask checks restart whenever `busy` falls, and the single-mode check reads the captured mode rather than the `mode` port. The stimulus drives `start` only on falling edges. It pulses `start` once during a busy run, with changed masks and data, to show that the pulse is ignored. It also uses VL values above NUM_ELEM on purpose, so that clamping stays inside the expected behaviour rather than being excluded.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

    typedef enum logic [1:0] {
        PM_TWIN     = 2'd0,
        PM_SINGLE   = 2'd1,
        PM_SRC_ONLY = 2'd2,
        PM_DST_ONLY = 2'd3
    } pred_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef struct packed {
        logic finish;
        logic fire;
        logic src_adv;
        logic dst_adv;
    } step_ctl_t;

    function automatic int unsigned clamp_len(input int unsigned v, input int unsigned lim);
        return (v > lim) ? lim : v;
    endfunction

    function automatic logic src_forced_full(input pred_mode_e m);
        return (m == PM_DST_ONLY);
    endfunction

    function automatic logic dst_forced_full(input pred_mode_e m);
        return (m == PM_SRC_ONLY);
    endfunction

    function automatic logic dst_follows_src(input pred_mode_e m);
        return (m == PM_SINGLE);
    endfunction

endpackage

// File: rtl/tpm_mask_sel.sv
module tpm_mask_sel
    import tpm_pkg::*;
#(
    parameter int unsigned NUM_ELEM = 8
) (
    input  pred_mode_e          mode,
    input  logic [NUM_ELEM-1:0] src_mask,
    input  logic [NUM_ELEM-1:0] dst_mask,
    output logic [NUM_ELEM-1:0] eff_src,
    output logic [NUM_ELEM-1:0] eff_dst
);

    localparam logic [NUM_ELEM-1:0] ALL_ONES = {NUM_ELEM{1'b1}};

    always_comb begin
        eff_src = src_forced_full(mode) ? ALL_ONES : src_mask;
        if (dst_forced_full(mode)) begin
            eff_dst = ALL_ONES;
        end else if (dst_follows_src(mode)) begin
            eff_dst = src_mask;
        end else begin
            eff_dst = dst_mask;
        end
    end

endmodule

// File: rtl/tpm_index_walk.sv
module tpm_index_walk #(
    parameter int unsigned NUM_ELEM = 8,
    localparam int unsigned CW = $clog2(NUM_ELEM + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                adv,
    input  logic [NUM_ELEM-1:0] mask,
    input  logic [CW-1:0]       len,
    output logic [CW-1:0]       idx,
    output logic                hit,
    output logic                at_end
);

    logic bit_sel;

    always_comb begin
        bit_sel = 1'b0;
        for (int k = 0; k < NUM_ELEM; k++) begin
            if (idx == CW'(k)) begin
                bit_sel = mask[k];
            end
        end
    end

    assign at_end = (idx >= len);
    assign hit    = !at_end && bit_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (clear) begin
            idx <= '0;
        end else if (adv) begin
            idx <= idx + CW'(1);
        end
    end

endmodule

// File: rtl/tpm_dst_bank.sv
module tpm_dst_bank #(
    parameter int unsigned NUM_ELEM = 8,
    parameter int unsigned ELEM_W   = 8,
    localparam int unsigned CW = $clog2(NUM_ELEM + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clear_we,
    input  logic                       wr_en,
    input  logic [CW-1:0]              wr_idx,
    input  logic [ELEM_W-1:0]          wr_data,
    output logic [NUM_ELEM*ELEM_W-1:0] data,
    output logic [NUM_ELEM-1:0]        we
);

    for (genvar g = 0; g < NUM_ELEM; g++) begin : g_slot
        logic sel;
        assign sel = wr_en && (wr_idx == CW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                data[g*ELEM_W +: ELEM_W] <= '0;
                we[g]                    <= 1'b0;
            end else begin
                if (sel) begin
                    data[g*ELEM_W +: ELEM_W] <= wr_data;
                end
                if (clear_we) begin
                    we[g] <= 1'b0;
                end else if (sel) begin
                    we[g] <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/twin_pred_mover.sv
module twin_pred_mover
    import tpm_pkg::*;
#(
    parameter int unsigned NUM_ELEM = 8,
    parameter int unsigned ELEM_W   = 8,
    localparam int unsigned CW = $clog2(NUM_ELEM + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [1:0]                 mode,
    input  logic [CW-1:0]              vl,
    input  logic [NUM_ELEM-1:0]        src_mask,
    input  logic [NUM_ELEM-1:0]        dst_mask,
    input  logic [NUM_ELEM*ELEM_W-1:0] src_data,
    output logic [NUM_ELEM*ELEM_W-1:0] dst_data,
    output logic [NUM_ELEM-1:0]        dst_we,
    output logic                       mv_valid,
    output logic [CW-1:0]              mv_src_idx,
    output logic [CW-1:0]              mv_dst_idx,
    output logic                       busy,
    output logic                       done
);

    run_state_e                  state;
    pred_mode_e                  mode_q;
    logic [CW-1:0]               vl_q;
    logic [NUM_ELEM-1:0]         eff_src_q;
    logic [NUM_ELEM-1:0]         eff_dst_q;
    logic [NUM_ELEM-1:0]         eff_src_in;
    logic [NUM_ELEM-1:0]         eff_dst_in;
    logic [NUM_ELEM*ELEM_W-1:0]  src_q;
    logic                        accept;
    step_ctl_t                   ctl;
    logic [CW-1:0]               s_idx, d_idx;
    logic                        s_hit, d_hit, s_end, d_end;
    logic [ELEM_W-1:0]           src_elem;

    assign accept = (state == ST_IDLE) && start;
    assign busy   = (state == ST_RUN);

    tpm_mask_sel #(.NUM_ELEM(NUM_ELEM)) u_mask_sel (
        .mode     (pred_mode_e'(mode)),
        .src_mask (src_mask),
        .dst_mask (dst_mask),
        .eff_src  (eff_src_in),
        .eff_dst  (eff_dst_in)
    );

    tpm_index_walk #(.NUM_ELEM(NUM_ELEM)) u_src_walk (
        .clk    (clk),
        .rst    (rst),
        .clear  (accept),
        .adv    (ctl.src_adv),
        .mask   (eff_src_q),
        .len    (vl_q),
        .idx    (s_idx),
        .hit    (s_hit),
        .at_end (s_end)
    );

    tpm_index_walk #(.NUM_ELEM(NUM_ELEM)) u_dst_walk (
        .clk    (clk),
        .rst    (rst),
        .clear  (accept),
        .adv    (ctl.dst_adv),
        .mask   (eff_dst_q),
        .len    (vl_q),
        .idx    (d_idx),
        .hit    (d_hit),
        .at_end (d_end)
    );

    always_comb begin
        ctl.finish  = busy && (s_end || d_end);
        ctl.fire    = busy && !ctl.finish && s_hit && d_hit;
        ctl.src_adv = busy && !ctl.finish && (!s_hit || ctl.fire);
        ctl.dst_adv = busy && !ctl.finish && (!d_hit || ctl.fire);
    end

    always_comb begin
        src_elem = '0;
        for (int k = 0; k < NUM_ELEM; k++) begin
            if (s_idx == CW'(k)) begin
                src_elem = src_q[k*ELEM_W +: ELEM_W];
            end
        end
    end

    tpm_dst_bank #(.NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .clear_we (accept),
        .wr_en    (ctl.fire),
        .wr_idx   (d_idx),
        .wr_data  (src_elem),
        .data     (dst_data),
        .we       (dst_we)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            mode_q     <= PM_TWIN;
            vl_q       <= '0;
            eff_src_q  <= '0;
            eff_dst_q  <= '0;
            src_q      <= '0;
            done       <= 1'b0;
            mv_valid   <= 1'b0;
            mv_src_idx <= '0;
            mv_dst_idx <= '0;
        end else begin
            done     <= ctl.finish;
            mv_valid <= ctl.fire;
            if (ctl.fire) begin
                mv_src_idx <= s_idx;
                mv_dst_idx <= d_idx;
            end
            if (accept) begin
                state     <= ST_RUN;
                mode_q    <= pred_mode_e'(mode);
                vl_q      <= CW'(clamp_len(32'(vl), NUM_ELEM));
                eff_src_q <= eff_src_in;
                eff_dst_q <= eff_dst_in;
                src_q     <= src_data;
            end else if (ctl.finish) begin
                state <= ST_IDLE;
            end
        end
    end

endmodule

// File: rtl/twin_pred_mover_chk.sv
module twin_pred_mover_chk
    import tpm_pkg::*;
#(
    parameter int unsigned NUM_ELEM = 8,
    parameter int unsigned ELEM_W   = 8,
    localparam int unsigned CW = $clog2(NUM_ELEM + 1)
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       busy,
    input logic                       done,
    input logic                       mv_valid,
    input logic [CW-1:0]              mv_src_idx,
    input logic [CW-1:0]              mv_dst_idx,
    input logic [NUM_ELEM*ELEM_W-1:0] dst_data,
    input logic [CW-1:0]              vl_q,
    input pred_mode_e                 mode_q,
    input logic [NUM_ELEM-1:0]        eff_src_q,
    input logic [NUM_ELEM-1:0]        eff_dst_q
);

    logic          seen;
    logic [CW-1:0] last_src, last_dst;
    logic [15:0]   run_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            seen     <= 1'b0;
            last_src <= '0;
            last_dst <= '0;
        end else if (mv_valid) begin
            seen     <= 1'b1;
            last_src <= mv_src_idx;
            last_dst <= mv_dst_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 16'd1;
        end
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_dst_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !mv_valid |-> $stable(dst_data));

    assert_move_in_len_R7: assert property (@(posedge clk) disable iff (rst)
        mv_valid |-> (mv_src_idx < vl_q) && (mv_dst_idx < vl_q));

    assert_move_masked_R8: assert property (@(posedge clk) disable iff (rst)
        mv_valid |-> (|(eff_src_q & (NUM_ELEM'(1) << mv_src_idx)))
                  && (|(eff_dst_q & (NUM_ELEM'(1) << mv_dst_idx))));

    assert_move_order_R8: assert property (@(posedge clk) disable iff (rst)
        (mv_valid && seen) |-> (mv_src_idx > last_src) && (mv_dst_idx > last_dst));

    assert_single_inplace_R4: assert property (@(posedge clk) disable iff (rst)
        (mv_valid && mode_q == PM_SINGLE) |-> (mv_src_idx == mv_dst_idx));

    assert_run_bound_R11: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_cnt <= 16'(2 * NUM_ELEM)));

endmodule

bind twin_pred_mover twin_pred_mover_chk #(.NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .done       (done),
    .mv_valid   (mv_valid),
    .mv_src_idx (mv_src_idx),
    .mv_dst_idx (mv_dst_idx),
    .dst_data   (dst_data),
    .vl_q       (vl_q),
    .mode_q     (mode_q),
    .eff_src_q  (eff_src_q),
    .eff_dst_q  (eff_dst_q)
);

// File: tb/twin_pred_mover_bench.sv
`timescale 1ns/1ps
module twin_pred_mover_bench;

    localparam int N  = 8;
    localparam int W  = 8;
    localparam int CW = 4;

    logic           clk = 1'b0;
    logic           rst;
    logic           start;
    logic [1:0]     mode;
    logic [CW-1:0]  vl;
    logic [N-1:0]   src_mask, dst_mask;
    logic [N*W-1:0] src_data, dst_data;
    logic [N-1:0]   dst_we;
    logic           mv_valid;
    logic [CW-1:0]  mv_src_idx, mv_dst_idx;
    logic           busy, done;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    logic [N*W-1:0] shadow;

    always #2.5 clk = ~clk;

    twin_pred_mover #(.NUM_ELEM(N), .ELEM_W(W)) u_twin_pred_mover (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .vl(vl),
        .src_mask(src_mask), .dst_mask(dst_mask), .src_data(src_data),
        .dst_data(dst_data), .dst_we(dst_we), .mv_valid(mv_valid),
        .mv_src_idx(mv_src_idx), .mv_dst_idx(mv_dst_idx),
        .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
        finish_up();
    end

    function automatic logic [N-1:0] eff_mask(input logic [1:0] m, input logic [N-1:0] sm,
                                              input logic [N-1:0] dm, input bit dst_side);
        if (!dst_side) return (m == 2'd3) ? {N{1'b1}} : sm;
        case (m)
            2'd1:    return sm;
            2'd2:    return {N{1'b1}};
            default: return dm;
        endcase
    endfunction

    task automatic run_op(input logic [1:0] m, input int v, input logic [N-1:0] sm,
                          input logic [N-1:0] dm, input logic [N*W-1:0] sd,
                          input string tag, input bit poke);
        logic [N-1:0]   es, ed, exp_we;
        logic [N*W-1:0] exp_data;
        int ps[N];
        int pd[N];
        int np = 0, got = 0, k = 0, i = 0, j = 0, vlc;
        bit pair_ok = 1, seen_done = 0;
        vlc = (v > N) ? N : v;
        es = eff_mask(m, sm, dm, 0);
        ed = eff_mask(m, sm, dm, 1);
        exp_data = shadow;
        exp_we = '0;
        forever begin
            while (i < vlc && !es[i]) i++;
            while (j < vlc && !ed[j]) j++;
            if (i >= vlc || j >= vlc) break;
            ps[np] = i; pd[np] = j; np++;
            exp_data[j*W +: W] = sd[i*W +: W];
            exp_we[j] = 1'b1;
            i++; j++;
        end

        @(negedge clk);
        mode = m; vl = CW'(v); src_mask = sm; dst_mask = dm; src_data = sd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        while (k < 100) begin
            if (mv_valid) begin
                if (got >= np || 32'(mv_src_idx) != ps[got] || 32'(mv_dst_idx) != pd[got]) pair_ok = 0;
                got++;
            end
            if (done) begin
                seen_done = 1;
                break;
            end
            if (poke && k == 1) begin
                start = 1'b1; src_mask = ~sm; dst_mask = ~dm; mode = m + 2'd1; src_data = ~sd;
            end
            @(negedge clk);
            start = 1'b0;
            k++;
        end
        check(seen_done && k <= 2 * vlc + 2, "R11 done latency", 64'(k), 64'(2 * vlc + 2));
        check(dst_data == exp_data, tag, dst_data, exp_data);
        check(dst_we == exp_we, "R3 write enables", 64'(dst_we), 64'(exp_we));
        check(pair_ok && got == np, "R8 move pairs", 64'(got), 64'(np));
        @(negedge clk);
        check(!done && !busy, "R9 done pulse", {62'd0, done, busy}, 64'd0);
        shadow = exp_data;
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; mode = '0; vl = '0;
        src_mask = '0; dst_mask = '0; src_data = '0;
        shadow = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !mv_valid && dst_we == '0 && dst_data == '0,
              "R1 reset state", {dst_data[59:0], busy, done, mv_valid, |dst_we}, 64'd0);

        // R10: all-ones masks copy
        run_op(2'd0, 8, 8'hFF, 8'hFF, 64'h8877665544332211, "R10 plain copy", 0);
        // R2: twin compress+expand
        run_op(2'd0, 8, 8'b1010_0110, 8'b0101_1001, 64'hA1B2C3D4E5F60718, "R2 twin", 0);
        // R3: empty destination mask -> nothing written
        run_op(2'd0, 8, 8'hFF, 8'h00, 64'h0102030405060708, "R3 untouched", 0);
        // R4: single mode ignores dst_mask
        run_op(2'd1, 8, 8'b0011_0101, 8'b1100_0000, 64'hDEADBEEFCAFEF00D, "R4 single", 0);
        // R5: source-only compress
        run_op(2'd2, 8, 8'b1001_0010, 8'h00, 64'h1122334455667788, "R5 compress", 0);
        // R6: destination-only expand
        run_op(2'd3, 8, 8'h00, 8'b0110_1001, 64'h99AABBCCDDEEFF00, "R6 expand", 0);
        // R7: zero length, clamp above NUM_ELEM, short length
        run_op(2'd0, 0, 8'hFF, 8'hFF, 64'h5555555555555555, "R7 zero length", 0);
        run_op(2'd0, 13, 8'hFF, 8'hFF, 64'h0F1E2D3C4B5A6978, "R7 clamped length", 0);
        run_op(2'd0, 3, 8'hFF, 8'hFF, 64'hFEDCBA9876543210, "R7 short length", 0);
        // R9: start during busy is ignored
        run_op(2'd0, 8, 8'b1110_1011, 8'b1011_0111, 64'h13579BDF2468ACE0, "R9 start ignored", 1);

        void'($urandom(32'd20240611));
        for (int t = 0; t < 150; t++) begin
            logic [1:0] rm;
            rm = 2'($urandom % 4);
            run_op(rm, int'($urandom % 11), N'($urandom), N'($urandom),
                   {$urandom, $urandom},
                   (rm == 2'd0) ? "R2 random twin" : (rm == 2'd1) ? "R4 random single" :
                   (rm == 2'd2) ? "R5 random compress" : "R6 random expand",
                   ($urandom % 8) == 0);
        end
        finish_up();
    end

endmodule